// File: doc/BRIEF.md
# Streaming Hamming Code Generator for 256-Byte Flash Chunks

This block computes the three-byte single-error-correcting Hamming code that small-page NAND flash stores next to each 256-byte chunk of data. The data arrives as a byte stream, one byte per cycle whenever the valid strobe is high. A start pulse opens a chunk. After the 256th accepted byte the block raises a one-cycle done pulse, and the three code bytes appear on the outputs in that same cycle.

Two sets of running values are kept. The first is a six-bit column parity that records which bit lanes of the data were odd. The second is a pair of line-parity registers. Each byte whose bits XOR to one folds its own index into the first register and the complement of that index into the second. At the end of the chunk the two line-parity registers are bit-interleaved into two bytes and inverted. A byte-order input, sampled on the start pulse, chooses which of those two bytes leads. The column parity is inverted and forms the third byte. An erased chunk, where every byte is 0xFF, produces a code of all 0xFF, and so does a chunk of all 0x00.

Top module: `nand_ecc_gen`

## Requirements
- R1: While reset is high and after it, until the first chunk completes, `done_o` is low and all three code outputs read 0xFF.
- R2: For each accepted byte, column bit c0 is the XOR of data bits 0, 2, 4 and 6. Bit c1 covers bits 1, 3, 5 and 7. Bit c2 covers bits 0, 1, 4 and 5. Bit c3 covers bits 2, 3, 6 and 7. Bit c4 covers bits 0 to 3, and bit c5 covers bits 4 to 7. These bits XOR into a running six-bit value C. The third output `ecc2_o` equals `{~C[5:0], 2'b11}`.
- R3: A byte at index i (0 to 255 within the chunk) whose eight bits XOR to 1 XORs i into line register A and ~i into line register B. A byte with even parity leaves both registers unchanged.
- R4: Define the upper byte U = ~{A7,B7,A6,B6,A5,B5,A4,B4} and the lower byte L = ~{A3,B3,A2,B2,A1,B1,A0,B0}, with the MSB first. In normal order (`byte_swap_i` = 0 at start), `ecc0_o` = U and `ecc1_o` = L.
- R5: When `byte_swap_i` is 1 in the start cycle, `ecc0_o` = L and `ecc1_o` = U for that chunk. The value of `byte_swap_i` at any other time has no effect.
- R6: `done_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the chunk's 256th byte. The code outputs take their new values in that same cycle.
- R7: The code outputs change only in a cycle where `done_o` is high. They do not change on start or on accepted bytes.
- R8: A cycle with `valid_i` low inside a chunk consumes no index, and the result is the same as for the gap-free stream.
- R9: A byte with `valid_i` high while no chunk is open (after reset, or after completion and before the next start) is ignored. It produces no done pulse and no change to the outputs.
- R10: A start pulse clears the accumulators and the index even in the middle of a chunk. A valid byte presented in the start cycle is taken as index 0 of the new chunk.
- R11: A chunk of 256 bytes of 0xFF, or of 256 bytes of 0x00, yields 0xFF on all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new chunk; clears the accumulators |
| byte_swap_i | input | 1 | Order of the two line-parity bytes, sampled with start |
| valid_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| ecc0_o | output | 8 | First code byte |
| ecc1_o | output | 8 | Second code byte |
| ecc2_o | output | 8 | Column-parity code byte |
| done_o | output | 1 | One-cycle pulse when a new code is presented |

## Verification
The bench aims at the index-folding path with a chunk that is all zero except one odd byte. It also covers a byte at the final index, where an off-by-one counter would close the chunk early or late and move the done pulse. Random streams with gaps, and restarts in mid-chunk, expose a counter that advances on idle cycles or keeps state across a restart; either fault gives a wrong code or a missing done. Bytes sent outside a chunk, and toggling of the order input after start, show a design that corrupts held outputs or samples the order at the wrong time. Uniform 0x00 and 0xFF chunks catch an inversion or a tail-bit error in the third byte.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CHUNK_LEN = 256;
    localparam int unsigned IDX_W     = $clog2(CHUNK_LEN);
    localparam int unsigned HALF_W    = IDX_W / 2;
    localparam int unsigned GRP_N     = $clog2(BYTE_W);
    localparam int unsigned COL_W     = 2 * GRP_N;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic {
        ORDER_NORMAL  = 1'b0,
        ORDER_SWAPPED = 1'b1
    } ecc_order_e;

    // per-byte contribution
    typedef struct packed {
        logic             odd;
        logic [COL_W-1:0] col;
    } byte_term_t;

    // running state of one chunk
    typedef struct packed {
        idx_t             line_a;
        idx_t             line_b;
        logic [COL_W-1:0] col;
    } ecc_acc_t;

    typedef struct packed {
        byte_t first;
        byte_t second;
        byte_t colb;
    } ecc_code_t;

    // Bits of a byte whose index has bit 'grp' equal to 'pol'.
    function automatic byte_t group_mask(int grp, int pol);
        byte_t m;
        for (int k = 0; k < BYTE_W; k++) begin
            m[k] = (((k >> grp) & 1) == pol);
        end
        return m;
    endfunction

endpackage

// File: rtl/nand_ecc_colpar.sv
module nand_ecc_colpar
    import nand_ecc_pkg::*;
(
    input  byte_t      data_i,
    output byte_term_t term_o
);

    logic [COL_W-1:0] col_w;

    // one parity pair per address-bit group of the byte lanes
    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        for (genvar p = 0; p < 2; p++) begin : g_pol
            assign col_w[2*g+p] = ^(data_i & group_mask(g, p));
        end
    end

    assign term_o.col = col_w;
    assign term_o.odd = ^data_i;

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
    import nand_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       order_i,
    input  logic       valid_i,
    input  byte_term_t term_i,
    output ecc_acc_t   fin_acc_o,
    output logic       fin_o,
    output ecc_order_e order_o
);

    ecc_acc_t   acc_q;
    ecc_acc_t   acc_upd;
    idx_t       cnt_q;
    idx_t       idx;
    logic       active_q;
    logic       accept;
    ecc_order_e order_q;

    assign accept = (start_i || active_q) && valid_i;
    assign idx    = start_i ? '0 : cnt_q;

    always_comb begin
        acc_upd = start_i ? '0 : acc_q;
        if (accept) begin
            acc_upd.col = acc_upd.col ^ term_i.col;
            if (term_i.odd) begin
                acc_upd.line_a = acc_upd.line_a ^ idx;
                acc_upd.line_b = acc_upd.line_b ^ ~idx;
            end
        end
    end

    assign fin_o     = accept && (idx == idx_t'(CHUNK_LEN - 1));
    assign fin_acc_o = acc_upd;
    assign order_o   = order_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            order_q  <= ORDER_NORMAL;
        end else begin
            if (start_i || accept) begin
                acc_q <= acc_upd;
                cnt_q <= accept ? idx_t'(idx + 1'b1) : '0;
            end
            if (start_i) begin
                order_q  <= ecc_order_e'(order_i);
                active_q <= ~fin_o;
            end else if (fin_o) begin
                active_q <= 1'b0;
            end
        end
    end

    // R9
    idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !start_i) |=> ($stable(cnt_q) && $stable(acc_q)));

endmodule

// File: rtl/nand_ecc_pack.sv
module nand_ecc_pack
    import nand_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fin_i,
    input  ecc_acc_t   acc_i,
    input  ecc_order_e order_i,
    output ecc_code_t  code_o,
    output logic       done_o
);

    byte_t     hi_w;
    byte_t     lo_w;
    ecc_code_t code_q;
    logic      done_q;

    // interleave A/B pairs, A in the odd position
    for (genvar j = 0; j < HALF_W; j++) begin : g_ilv
        assign lo_w[2*j+1] = acc_i.line_a[j];
        assign lo_w[2*j]   = acc_i.line_b[j];
        assign hi_w[2*j+1] = acc_i.line_a[j+HALF_W];
        assign hi_w[2*j]   = acc_i.line_b[j+HALF_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '1;
            done_q <= 1'b0;
        end else begin
            done_q <= fin_i;
            if (fin_i) begin
                if (order_i == ORDER_SWAPPED) begin
                    code_q.first  <= ~lo_w;
                    code_q.second <= ~hi_w;
                end else begin
                    code_q.first  <= ~hi_w;
                    code_q.second <= ~lo_w;
                end
                code_q.colb <= {~acc_i.col, 2'b11};
            end
        end
    end

    assign code_o = code_q;
    assign done_o = done_q;

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       byte_swap_i,
    input  logic       valid_i,
    input  logic [7:0] data_i,
    output logic [7:0] ecc0_o,
    output logic [7:0] ecc1_o,
    output logic [7:0] ecc2_o,
    output logic       done_o
);

    byte_term_t term;
    ecc_acc_t   fin_acc;
    logic       fin;
    ecc_order_e order;
    ecc_code_t  code;

    nand_ecc_colpar i_colpar (
        .data_i (data_i),
        .term_o (term)
    );

    nand_ecc_accum i_accum (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .order_i   (byte_swap_i),
        .valid_i   (valid_i),
        .term_i    (term),
        .fin_acc_o (fin_acc),
        .fin_o     (fin),
        .order_o   (order)
    );

    nand_ecc_pack i_pack (
        .clk     (clk),
        .rst     (rst),
        .fin_i   (fin),
        .acc_i   (fin_acc),
        .order_i (order),
        .code_o  (code),
        .done_o  (done_o)
    );

    assign ecc0_o = code.first;
    assign ecc1_o = code.second;
    assign ecc2_o = code.colb;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    done_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(valid_i));

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !done_o) |-> $stable({ecc0_o, ecc1_o, ecc2_o}));

    // R2
    col_tail_chk: assert property (@(posedge clk) disable iff (rst)
        ecc2_o[1:0] == 2'b11);

endmodule

// File: tb/test_nand_ecc_gen.sv
module test_nand_ecc_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       byte_swap_i = 1'b0;
    logic       valid_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic [7:0] ecc0_o, ecc1_o, ecc2_o;
    logic       done_o;

    always #4 clk = ~clk;

    nand_ecc_gen i_nand_ecc_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .byte_swap_i(byte_swap_i),
        .valid_i(valid_i), .data_i(data_i),
        .ecc0_o(ecc0_o), .ecc1_o(ecc1_o), .ecc2_o(ecc2_o), .done_o(done_o)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 0;
    string      tag = "R1";
    logic [31:0] lcg = 32'h1234_5678;

    // behavioural model state
    bit         m_active = 0;
    bit         m_swap = 0;
    byte        m_q[$];
    logic [7:0] x0 = 8'hFF, x1 = 8'hFF, x2 = 8'hFF;
    logic       xdone = 0;

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] got %02h expected %02h at %0t", req, tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[23:16];
    endfunction

    function automatic void model_code();
        int a = 0, b = 0, c = 0, hi = 0, lo = 0;
        int col[6] = '{0, 0, 0, 0, 0, 0};
        for (int i = 0; i < 256; i++) begin
            int d = int'(m_q[i]) & 255;
            int par = 0;
            for (int k = 0; k < 8; k++) begin
                if ((d >> k) & 1) begin
                    par ^= 1;
                    col[k % 2] ^= 1;
                    col[2 + (k / 2) % 2] ^= 1;
                    col[4 + k / 4] ^= 1;
                end
            end
            if (par) begin
                a ^= i;
                b ^= (~i) & 255;
            end
        end
        for (int k = 0; k < 4; k++) begin
            hi |= (((a >> (k + 4)) & 1) << (2 * k + 1)) | (((b >> (k + 4)) & 1) << (2 * k));
            lo |= (((a >> k) & 1) << (2 * k + 1)) | (((b >> k) & 1) << (2 * k));
        end
        for (int k = 0; k < 6; k++) c |= col[k] << k;
        x0 = m_swap ? 8'(~lo) : 8'(~hi);
        x1 = m_swap ? 8'(~hi) : 8'(~lo);
        x2 = 8'((((~c) & 63) << 2) | 3);
    endfunction

    // one clock: drive, advance model, compare at the next falling edge
    task automatic step(bit s, bit v, logic [7:0] d, bit sw);
        bit acc;
        start_i = s; valid_i = v; data_i = d; byte_swap_i = sw;
        acc = (s || m_active) && v;
        if (s) begin
            m_q.delete();
            m_active = 1;
            m_swap = sw;
        end
        xdone = 0;
        if (acc) begin
            m_q.push_back(d);
            if (m_q.size() == 256) begin
                model_code();
                xdone = 1;
                m_active = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R6", {7'd0, done_o}, {7'd0, xdone});
        chk("R4", ecc0_o, x0);
        chk("R4", ecc1_o, x1);
        chk("R2", ecc2_o, x2);
    endtask

    // kind: 0 constant, 1 random, 2 single odd byte at index 'pos'
    task automatic chunk(int kind, logic [7:0] val, int pos, bit sw, bit gaps);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            if (gaps) begin
                while (rnd() < 8'd80) step(0, 0, rnd(), ~sw);
            end
            d = (kind == 0) ? val : (kind == 1) ? rnd() : ((i == pos) ? val : 8'h00);
            step(i == 0, 1, d, (i == 0) ? sw : rnd() > 8'd127);
        end
        step(0, 0, 8'h00, 0);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1", {7'd0, done_o}, 8'd0);
        chk("R1", ecc0_o, 8'hFF);
        chk("R1", ecc1_o, 8'hFF);
        chk("R1", ecc2_o, 8'hFF);
        rst = 0;
        tag = "R9";
        for (int i = 0; i < 10; i++) step(0, 1, rnd(), 0);

        tag = "R11";
        chunk(0, 8'hFF, 0, 0, 0);
        chk("R11", ecc0_o, 8'hFF); chk("R11", ecc1_o, 8'hFF); chk("R11", ecc2_o, 8'hFF);
        chunk(0, 8'h00, 0, 1, 0);
        chk("R11", ecc0_o, 8'hFF); chk("R11", ecc1_o, 8'hFF); chk("R11", ecc2_o, 8'hFF);

        // byte 0 = 0x01: A=0x00, B=0xFF -> AA AA AB
        tag = "R3";
        chunk(2, 8'h01, 0, 0, 0);
        chk("R3", ecc0_o, 8'hAA); chk("R3", ecc1_o, 8'hAA); chk("R2", ecc2_o, 8'hAB);
        chunk(2, 8'h80, 255, 0, 0);
        chunk(2, 8'h07, 8'h5A, 0, 0);
        chunk(2, 8'h03, 8'h33, 0, 0);

        tag = "R4";
        chunk(1, 0, 0, 0, 0);
        tag = "R5";
        chunk(1, 0, 0, 1, 0);
        chunk(2, 8'h01, 8'h0F, 1, 0);

        tag = "R8";
        chunk(1, 0, 0, 0, 1);
        chunk(1, 0, 0, 1, 1);

        tag = "R9";
        for (int i = 0; i < 30; i++) step(0, 1, rnd(), rnd() > 8'd127);

        tag = "R10";
        for (int i = 0; i < 100; i++) step(i == 0, 1, rnd(), 1);
        step(0, 0, 8'h00, 0);
        tag = "R7";
        for (int i = 0; i < 40; i++) step(i == 0, 1, rnd(), 0);
        tag = "R10";
        chunk(1, 0, 0, 0, 0);
        step(1, 0, 8'h00, 1);
        for (int i = 0; i < 256; i++) step(0, 1, rnd(), 0);
        step(0, 0, 8'h00, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog [%s] got hung expected finish", tag);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule